// File: doc/BRIEF.md
# Sleep Entry and Recovery Sequencer

This block controls a low-power sleep state for a synchronous memory's cycle controller. An active-high sleep request can arrive with no relation to the clock. It is first brought into the clock domain. A short entry window then runs before the controller is blocked and the data bus is forced to high impedance. Dropping the request starts a matching recovery window, and the block stays in force until that window ends. The array contents are never touched, so no state is lost across a sleep period.

The sequencer also checks the protocol around the two windows. If the device is selected while a request is being taken in, or if any enable or address strobe goes active during recovery, a sticky error flag is raised. A one-cycle abort pulse marks the moment sleep takes hold, so the controller can drop any access still pending as invalid. The synchroniser flops reset to the awake level, which matches an undriven request input.

Top module: `lp_sleep_seq`

## Requirements
- R1: After reset, block_o, dq_hiz_o, abort_o and err_o are all 0.
- R2: After sleep_req_i goes high and stays high, block_o rises on the 5th rising clock edge: 2 edges of synchronisation, 1 edge to detect the request, and an entry window of ENTRY_CYC = 2 edges.
- R3: After sleep_req_i goes low and stays low while asleep, block_o falls on the 5th rising edge: 2 edges of synchronisation, 1 edge to detect the drop, and a recovery window of EXIT_CYC = 2 edges.
- R4: dq_hiz_o is high for exactly the cycles in which block_o is high, which covers both the sleeping and the recovery cycles.
- R5: abort_o is high for exactly one cycle, the first cycle in which block_o is high.
- R6: A request that is seen by the synchroniser but drops before the entry window completes returns the block to awake, and block_o never rises.
- R7: If the device is selected (ce_a_ni = 0, ce_b_i = 1 and ce_c_ni = 0 at once) while the synchronised request is high and sleep has not yet been reached, err_o is 1 after the next rising edge.
- R8: During the recovery window, any one of ce_a_ni = 0, ce_b_i = 1, ce_c_ni = 0, ads_proc_ni = 0 or ads_ctl_ni = 0 sets err_o after the next rising edge.
- R9: While fully asleep, selection and strobe activity are ignored: err_o stays 0 and block_o stays 1.
- R10: err_o stays 1 once set, until rst_ni is asserted.
- R11: A request that returns during the recovery window sends the block back to sleep, and block_o does not drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Sleep request, asynchronous, active high |
| ce_a_ni | input | 1 | Chip enable A, active low |
| ce_b_i | input | 1 | Chip enable B, active high |
| ce_c_ni | input | 1 | Chip enable C, active low |
| ads_proc_ni | input | 1 | Processor address strobe, active low |
| ads_ctl_ni | input | 1 | Controller address strobe, active low |
| block_o | output | 1 | Blocks all other inputs to the cycle controller |
| dq_hiz_o | output | 1 | Forces the data bus to high impedance |
| abort_o | output | 1 | One-cycle pulse: the pending access is invalid |
| err_o | output | 1 | Sticky protocol violation flag |

## Verification
The bench counts edges around the windows exactly. A design with a missing synchroniser stage, or with an entry or recovery window off by one, moves the edge of block_o and fails the sampled cycle. A single-cycle request pulse checks the aborted entry: a sequencer that latches the request would go to sleep and never come back. Selection while fully asleep must be ignored, while a lone active-high enable during recovery must be caught. The bench also confirms that a request returning mid-recovery holds the block without a gap, and that the error flag survives until reset.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ENTER  = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_WAKE   = 2'd3
  } slp_state_e;
endpackage

// File: rtl/lp_sleep_sync.sv
module lp_sleep_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lp_sleep_fsm.sv
module lp_sleep_fsm
  import lp_sleep_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_s_i,
  output slp_state_e state_o,
  output logic       abort_o
);
  localparam int MAX_CYC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  slp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             abort_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: begin
        cnt_d = '0;
        if (req_s_i) state_d = ST_ENTER;
      end
      ST_ENTER: begin
        if (!req_s_i) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else if (cnt_q == ENTRY_LAST) begin
          state_d = ST_ASLEEP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ASLEEP: begin
        cnt_d = '0;
        if (!req_s_i) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (req_s_i) begin
          // request returned mid-recovery: stay blocked
          state_d = ST_ASLEEP;
          cnt_d   = '0;
        end else if (cnt_q == EXIT_LAST) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      abort_q <= (state_q == ST_ENTER) && (state_d == ST_ASLEEP);
    end
  end

  assign state_o = state_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/lp_sleep_guard.sv
module lp_sleep_guard
  import lp_sleep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  slp_state_e state_i,
  input  logic       req_s_i,
  input  logic       sel_all_i,
  input  logic       any_act_i,
  output logic       err_o
);
  logic err_q, entry_viol, recov_viol;

  assign entry_viol = sel_all_i &&
                      (((state_i == ST_AWAKE) && req_s_i) || (state_i == ST_ENTER));
  assign recov_viol = any_act_i && (state_i == ST_WAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | entry_viol | recov_viol;
  end

  assign err_o = err_q;
endmodule

// File: rtl/lp_sleep_seq.sv
module lp_sleep_seq
  import lp_sleep_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter int   ENTRY_CYC   = 2,
  parameter int   EXIT_CYC    = 2,
  parameter logic REQ_IDLE    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic ce_a_ni,
  input  logic ce_b_i,
  input  logic ce_c_ni,
  input  logic ads_proc_ni,
  input  logic ads_ctl_ni,
  output logic block_o,
  output logic dq_hiz_o,
  output logic abort_o,
  output logic err_o
);
  logic       req_s, sel_all, any_act;
  slp_state_e state;

  assign sel_all = !ce_a_ni && ce_b_i && !ce_c_ni;
  assign any_act = !ce_a_ni || ce_b_i || !ce_c_ni || !ads_proc_ni || !ads_ctl_ni;

  lp_sleep_sync #(.STAGES(SYNC_STAGES), .RST_VAL(REQ_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (req_s)
  );

  lp_sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_s_i(req_s),
    .state_o(state),
    .abort_o(abort_o)
  );

  lp_sleep_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .req_s_i  (req_s),
    .sel_all_i(sel_all),
    .any_act_i(any_act),
    .err_o    (err_o)
  );

  assign block_o  = (state == ST_ASLEEP) || (state == ST_WAKE);
  assign dq_hiz_o = block_o;
endmodule

// File: rtl/lp_sleep_seq_chk.sv
module lp_sleep_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_req_i,
  input logic block_o,
  input logic dq_hiz_o,
  input logic abort_o,
  input logic err_o
);
  AST_ENTRY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(block_o) |-> ($past(sleep_req_i, 1) && $past(sleep_req_i, 2) && $past(sleep_req_i, 3))); // R2
  AST_EXIT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(block_o) |-> (!$past(sleep_req_i, 1) && !$past(sleep_req_i, 2) && !$past(sleep_req_i, 3))); // R3
  AST_HIZ_TRACKS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_hiz_o == block_o); // R4
  AST_ABORT_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (block_o && $rose(block_o))); // R5
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
endmodule

bind lp_sleep_seq lp_sleep_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sleep_req_i(sleep_req_i),
  .block_o    (block_o),
  .dq_hiz_o   (dq_hiz_o),
  .abort_o    (abort_o),
  .err_o      (err_o)
);

// File: tb/tb_lp_sleep_seq.sv
`timescale 1ns/1ps
module tb_lp_sleep_seq;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sleep_req_i = 1'b0, ce_a_ni = 1'b1, ce_b_i = 1'b0, ce_c_ni = 1'b1;
  logic ads_proc_ni = 1'b1, ads_ctl_ni = 1'b1;
  logic block_o, dq_hiz_o, abort_o, err_o;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  lp_sleep_seq dut (.*);

  // {req, sel, strobe, exp_block, exp_abort, exp_err}; one edge per row
  localparam logic [5:0] VEC [14] = '{
    6'b100000, 6'b100000, 6'b100000, 6'b100000, 6'b100110, 6'b100100,
    6'b111100, 6'b000100, 6'b000100, 6'b000100, 6'b000100, 6'b000000,
    6'b011000, 6'b000000};

  task automatic drive(input logic req, input logic sel, input logic stb);
    sleep_req_i = req;
    ce_a_ni = !sel; ce_b_i = sel; ce_c_ni = !sel;
    ads_proc_ni = !stb; ads_ctl_ni = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
    step(2);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 block", block_o, 1'b0);
    chk("R1 hiz", dq_hiz_o, 1'b0);
    chk("R1 abort", abort_o, 1'b0);
    chk("R1 err", err_o, 1'b0);

    // R2 R3 R4 R5 R9: full sleep cycle walked from the table
    for (int i = 0; i < 14; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3]);
      step(1);
      chk($sformatf("R2/R3 block row %0d", i), block_o, VEC[i][2]);
      chk($sformatf("R4 hiz row %0d", i), dq_hiz_o, VEC[i][2]);
      chk($sformatf("R5 abort row %0d", i), abort_o, VEC[i][1]);
      chk($sformatf("R9 err row %0d", i), err_o, VEC[i][0]);
    end

    // R6: single-cycle request pulse never reaches sleep
    do_reset();
    drive(1'b1, 1'b0, 1'b0);
    step(1);
    drive(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R6 block", block_o, 1'b0);
    end

    // R7: selection during entry window
    do_reset();
    drive(1'b1, 1'b0, 1'b0);
    step(3);
    chk("R7 err before", err_o, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    step(1);
    chk("R7 err", err_o, 1'b1);
    // R10: sticky through a full sleep and wake
    drive(1'b1, 1'b0, 1'b0);
    step(6);
    drive(1'b0, 1'b0, 1'b0);
    step(8);
    chk("R10 err held", err_o, 1'b1);
    do_reset();
    chk("R10 err cleared", err_o, 1'b0);

    // R8: lone active-high enable during recovery
    drive(1'b1, 1'b0, 1'b0);
    step(6);
    chk("R8 asleep", block_o, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    step(3);
    chk("R8 err before", err_o, 1'b0);
    sleep_req_i = 1'b0; ce_b_i = 1'b1;
    step(1);
    chk("R8 err", err_o, 1'b1);

    // R8: controller strobe alone during recovery
    do_reset();
    drive(1'b1, 1'b0, 1'b0);
    step(6);
    drive(1'b0, 1'b0, 1'b0);
    step(3);
    ads_ctl_ni = 1'b0;
    step(1);
    chk("R8 strobe err", err_o, 1'b1);

    // R11: request returns during recovery
    do_reset();
    drive(1'b1, 1'b0, 1'b0);
    step(6);
    drive(1'b0, 1'b0, 1'b0);
    step(2);
    drive(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk("R11 block", block_o, 1'b1);
    end
    chk("R11 err", err_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule